// File: doc/BRIEF.md
# Mode Register Write Engine

This block turns a single mode-register write request into the command sequence a DDR4 memory controller expects on its mode-register port. A request carries a register index, a data word, a command type, a one-hot rank select, a DRAM-type flag and an address-mirroring enable. The block captures these fields when it accepts the request. It then runs a guarded busy handshake, builds the command and data words, and fires a single-cycle trigger. It signals completion once the controller reports idle again.

The guarded handshake works around a known controller defect. Before any command is built, the engine fires a preliminary trigger. It then requires two successive idle readings of the controller's busy flag. If the second reading shows busy, it returns to waiting. When the odd rank is addressed and mirroring is enabled, the bank-address bits of the register index and selected data bits are swapped. The swap pattern differs between DDR4 and other DRAM types. The busy input is asynchronous to the engine and passes through a synchronizer.

Top module: `mr_write_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_trig` and `done` are 0, and `cmd_word` and `cmd_data` are all zeros.
- R2: A request is accepted only while `req_ready` is 1. In the cycle after acceptance, `req_ready` is 0 until the `done` pulse has completed. A `req_valid` asserted while `req_ready` is 0 has no effect on the words issued or on the number of triggers.
- R3: Every request first produces a preliminary one-cycle trigger. The command trigger is issued only after two consecutive synchronized busy samples read 0. While busy stays high, no second trigger occurs.
- R4: The layout of `cmd_word` is: type in bits [1:0], rank select in bits [5:4], and register index in bits [14:12]. All other bits are 0. The data is driven separately on `cmd_data`.
- R5: Mirroring applies only when the captured `mirror_en` is 1 and the rank select equals 2'b10. Otherwise the index and data pass through unchanged, including data bits 14 to 17.
- R6: A mirrored register index keeps bit 2 and swaps bits 0 and 1.
- R7: Mirrored DDR4 data (`req_ddr4`=1) keeps bits 0, 1, 2, 9, 10 and 12. It swaps the pairs 3/4, 5/6, 7/8 and 11/13, and clears every other bit.
- R8: Mirrored non-DDR4 data (`req_ddr4`=0) keeps bits 0, 1, 2 and 9 through 15. It swaps the pairs 3/4, 5/6 and 7/8, and clears bits 16 and 17.
- R9: `cmd_word` and `cmd_data` take their new values at least one cycle before the command trigger, and hold them while it is high. Each trigger lasts exactly one cycle.
- R10: After the command trigger, `done` pulses for exactly one cycle once synchronized busy reads 0. There are exactly two triggers per request.
- R11: `ctl_busy` passes through a two-stage synchronizer. Once busy falls, the second trigger follows 5 cycles later when the engine is waiting before issue. Once busy falls after the command trigger, `done` follows 3 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Engine idle, request can be accepted |
| req_idx | input | 3 | Mode register index |
| req_data | input | 18 | Mode register data |
| req_type | input | 2 | Command type |
| req_rank | input | 2 | One-hot rank select |
| req_ddr4 | input | 1 | 1 for DDR4 mirror pattern, 0 for other types |
| mirror_en | input | 1 | Address mirroring enable for the odd rank |
| done | output | 1 | One-cycle completion pulse |
| cmd_word | output | 32 | Command word to the controller |
| cmd_data | output | 18 | Data word to the controller |
| cmd_trig | output | 1 | One-cycle trigger pulse |
| ctl_busy | input | 1 | Controller busy flag, asynchronous |

## Verification
On every cycle, the assertions check the following. Triggers last a single cycle. A command is built only directly after two idle busy samples. The words hold steady through the command trigger. `done` follows only an idle busy sample, and captured fields do not change while a request is in flight. The bit mappings for each mirroring case, the exact latency through the synchronizer, and the rule that a request arriving mid-operation is ignored can only be shown by the bench's scenarios. Those scenarios drive vectors with known expected words, a busy line held high externally, and a second request presented during a running one.

// File: rtl/mr_write_engine.sv
module mr_write_engine #(
  parameter int IDX_W       = 3,
  parameter int DATA_W      = 18,
  parameter int TYPE_W      = 2,
  parameter int RANK_W      = 2,
  parameter int CMD_W       = 32,
  parameter int RANK_POS    = 4,
  parameter int IDX_POS     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [RANK_W-1:0] req_rank,
  input  logic              req_ddr4,
  input  logic              mirror_en,
  output logic              done,
  output logic [CMD_W-1:0]  cmd_word,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_trig,
  input  logic              ctl_busy
);

  localparam int HOLD_CYC = SYNC_STAGES + 2;
  localparam int CNT_W    = $clog2(HOLD_CYC + 1);
  localparam logic [RANK_W-1:0] ODD_RANK = RANK_W'(2);
  localparam logic [DATA_W-1:0] KEEP_D4  = DATA_W'(16'h1607);
  localparam logic [DATA_W-1:0] KEEP_OTH = DATA_W'(16'hFE07);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_HOLD1, S_WAIT1, S_CHK2,
    S_BUILD, S_FIRE, S_HOLD2, S_WAITD, S_DONE
  } st_t;

  st_t st;
  logic [CNT_W-1:0]       cnt;
  logic [SYNC_STAGES-1:0] bsync;
  logic                   busy_s;

  logic [IDX_W-1:0]  r_idx;
  logic [DATA_W-1:0] r_data;
  logic [TYPE_W-1:0] r_type;
  logic [RANK_W-1:0] r_rank;
  logic              r_ddr4, r_mir;

  logic              do_mir;
  logic [IDX_W-1:0]  m_idx;
  logic [DATA_W-1:0] m_data;
  logic [CMD_W-1:0]  w_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bsync <= '0;
    else        bsync <= {bsync[SYNC_STAGES-2:0], ctl_busy};

  assign busy_s    = bsync[SYNC_STAGES-1];
  assign req_ready = (st == S_IDLE);
  assign cmd_trig  = (st == S_PRE) || (st == S_FIRE);
  assign done      = (st == S_DONE);
  assign do_mir    = r_mir && (r_rank == ODD_RANK);

  always_comb begin
    m_idx = r_idx;
    if (do_mir) begin
      m_idx[0] = r_idx[1];
      m_idx[1] = r_idx[0];
    end
  end

  always_comb begin
    m_data = r_data;
    if (do_mir) begin
      m_data = r_data & (r_ddr4 ? KEEP_D4 : KEEP_OTH);
      m_data[3] = r_data[4];
      m_data[4] = r_data[3];
      m_data[5] = r_data[6];
      m_data[6] = r_data[5];
      m_data[7] = r_data[8];
      m_data[8] = r_data[7];
      if (r_ddr4) begin
        m_data[11] = r_data[13];
        m_data[13] = r_data[11];
      end
    end
  end

  always_comb begin
    w_next = '0;
    w_next[TYPE_W-1:0]          = r_type;
    w_next[RANK_POS +: RANK_W]  = r_rank;
    w_next[IDX_POS  +: IDX_W]   = m_idx;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_idx  <= '0;
      r_data <= '0;
      r_type <= '0;
      r_rank <= '0;
      r_ddr4 <= 1'b0;
      r_mir  <= 1'b0;
    end else if (st == S_IDLE && req_valid) begin
      r_idx  <= req_idx;
      r_data <= req_data;
      r_type <= req_type;
      r_rank <= req_rank;
      r_ddr4 <= req_ddr4;
      r_mir  <= mirror_en;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cmd_word <= '0;
      cmd_data <= '0;
    end else begin
      case (st)
        S_IDLE:  if (req_valid) st <= S_PRE;
        S_PRE: begin
          cnt <= CNT_W'(HOLD_CYC - 1);
          st  <= S_HOLD1;
        end
        S_HOLD1: if (cnt == '0) st <= S_WAIT1; else cnt <= cnt - 1'b1;
        S_WAIT1: if (!busy_s) st <= S_CHK2;
        S_CHK2:
          if (busy_s) st <= S_WAIT1;
          else begin
            cmd_word <= w_next;
            cmd_data <= m_data;
            st       <= S_BUILD;
          end
        S_BUILD: st <= S_FIRE;
        S_FIRE: begin
          cnt <= CNT_W'(HOLD_CYC - 1);
          st  <= S_HOLD2;
        end
        S_HOLD2: if (cnt == '0) st <= S_WAITD; else cnt <= cnt - 1'b1;
        S_WAITD: if (!busy_s) st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  // R9
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_trig |=> !cmd_trig);

  // R3
  build_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUILD) |-> ($past(st) == S_CHK2) && !$past(busy_s));

  // R3
  chk2_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK2) |-> ($past(st) == S_WAIT1) && !$past(busy_s));

  // R9
  words_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIRE) |-> $stable(cmd_word) && $stable(cmd_data));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(busy_s) && ($past(st) == S_WAITD));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R2
  fields_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(r_idx) && $stable(r_data) && $stable(r_rank) && $stable(r_mir));

endmodule

// File: tb/mr_write_engine_tb_top.sv
module mr_write_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  typedef struct packed {
    logic        mir;
    logic [1:0]  rank;
    logic        ddr4;
    logic [2:0]  idx;
    logic [1:0]  typ;
    logic [17:0] data;
    logic [31:0] ecmd;
    logic [17:0] edat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    {1'b1, 2'b10, 1'b1, 3'b001, 2'd0, 18'h00008, 32'h00002020, 18'h00010},
    {1'b1, 2'b10, 1'b1, 3'b110, 2'd1, 18'h00800, 32'h00005021, 18'h02000},
    {1'b1, 2'b10, 1'b0, 3'b011, 2'd0, 18'h00820, 32'h00003020, 18'h00840},
    {1'b1, 2'b01, 1'b1, 3'b001, 2'd0, 18'h00008, 32'h00001010, 18'h00008},
    {1'b0, 2'b10, 1'b1, 3'b001, 2'd0, 18'h00008, 32'h00001020, 18'h00008},
    {1'b1, 2'b10, 1'b1, 3'b101, 2'd2, 18'h001C0, 32'h00006022, 18'h001A0},
    {1'b1, 2'b10, 1'b1, 3'b000, 2'd3, 18'h3D607, 32'h00000023, 18'h01607},
    {1'b1, 2'b10, 1'b0, 3'b111, 2'd0, 18'h3D607, 32'h00007020, 18'h0D607},
    {1'b1, 2'b01, 1'b1, 3'b110, 2'd1, 18'h3FFFF, 32'h00006011, 18'h3FFFF}
  };
  localparam string VTAG [NV] = '{"R6 R7", "R7", "R8", "R5", "R5", "R6 R7", "R7", "R8", "R5"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ddr4 = 1'b0, mirror_en = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [17:0] req_data = '0;
  logic [1:0]  req_type = '0, req_rank = '0;
  logic        req_ready, done, cmd_trig;
  logic [31:0] cmd_word;
  logic [17:0] cmd_data;
  logic        ext_busy = 1'b0;
  int          rem = 0;
  wire         ctl_busy = ext_busy || (rem != 0);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int trig_n = 0, done_n = 0;
  logic stable_bad = 1'b0, busy_at_done = 1'b0;
  logic [31:0] cap_cmd, prev_cmd;
  logic [17:0] cap_dat, prev_dat;

  always #(CLK_PERIOD/2) clk = ~clk;

  mr_write_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_data(req_data), .req_type(req_type), .req_rank(req_rank),
    .req_ddr4(req_ddr4), .mirror_en(mirror_en), .done(done), .cmd_word(cmd_word),
    .cmd_data(cmd_data), .cmd_trig(cmd_trig), .ctl_busy(ctl_busy)
  );

  always @(negedge clk) begin
    if (cmd_trig) begin
      trig_n = trig_n + 1;
      if (trig_n == 2) begin
        cap_cmd = cmd_word;
        cap_dat = cmd_data;
        if (cmd_word !== prev_cmd || cmd_data !== prev_dat) stable_bad = 1'b1;
      end
      rem = $urandom_range(1, 6);
    end else if (rem > 0) rem = rem - 1;
    if (done) begin
      done_n = done_n + 1;
      if (ctl_busy) busy_at_done = 1'b1;
    end
    prev_cmd = cmd_word;
    prev_dat = cmd_data;
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_mon();
    trig_n = 0; done_n = 0; stable_bad = 1'b0; busy_at_done = 1'b0;
  endtask

  task automatic put(input vec_t v);
    req_idx = v.idx; req_data = v.data; req_type = v.typ;
    req_rank = v.rank; req_ddr4 = v.ddr4; mirror_en = v.mir;
  endtask

  task automatic issue(input vec_t v);
    step();
    clear_mon();
    put(v);
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 200 && done_n == 0; k++) step();
  endtask

  initial begin
    step();
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(cmd_trig == 1'b0 && done == 1'b0, "R1", "trig/done in reset", {cmd_trig, done}, 0);
    chk(cmd_word == '0 && cmd_data == '0, "R1", "words in reset", cmd_word, 0);
    step();
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      wait_done();
      step();
      chk(cap_cmd == VEC[i].ecmd, "R4", $sformatf("cmd word vec %0d", i), cap_cmd, VEC[i].ecmd);
      chk(cap_dat == VEC[i].edat, VTAG[i], $sformatf("data vec %0d", i), cap_dat, VEC[i].edat);
      chk(trig_n == 2, "R10", $sformatf("trigger count vec %0d", i), trig_n, 2);
      chk(done_n == 1, "R10", $sformatf("done count vec %0d", i), done_n, 1);
      chk(!stable_bad, "R9", $sformatf("words settled before trigger vec %0d", i), stable_bad, 0);
      chk(!busy_at_done, "R10", $sformatf("busy low at done vec %0d", i), busy_at_done, 0);
      chk(req_ready == 1'b1, "R2", $sformatf("ready after done vec %0d", i), req_ready, 1);
    end

    // R3 / R11: busy held high blocks the command trigger
    ext_busy = 1'b1;
    issue(VEC[0]);
    for (int k = 0; k < 30; k++) step();
    chk(trig_n == 1, "R3", "only preliminary trigger while busy", trig_n, 1);
    ext_busy = 1'b0;
    for (int k = 0; k < 4; k++) step();
    chk(trig_n == 1, "R11", "no trigger 4 cycles after release", trig_n, 1);
    step();
    chk(trig_n == 2, "R11", "trigger 5 cycles after release", trig_n, 2);
    ext_busy = 1'b1;
    for (int k = 0; k < 20; k++) step();
    chk(done_n == 0, "R10", "no done while busy", done_n, 0);
    ext_busy = 1'b0;
    step(); step();
    chk(done_n == 0, "R11", "no done 2 cycles after release", done_n, 0);
    step();
    chk(done_n == 1, "R11", "done 3 cycles after release", done_n, 1);
    chk(cap_cmd == VEC[0].ecmd, "R4", "cmd word after busy hold", cap_cmd, VEC[0].ecmd);

    // R2: a request presented mid-operation is ignored
    issue(VEC[1]);
    step();
    put(VEC[4]);
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    wait_done();
    for (int k = 0; k < 12; k++) step();
    chk(cap_cmd == VEC[1].ecmd, "R2", "cmd word unaffected by busy-time request", cap_cmd, VEC[1].ecmd);
    chk(cap_dat == VEC[1].edat, "R2", "data unaffected by busy-time request", cap_dat, VEC[1].edat);
    chk(trig_n == 2, "R2", "no extra triggers from ignored request", trig_n, 2);

    summary();
  end
endmodule